// File: doc/BRIEF.md
# Four-Level Priority Interrupt Controller

This block arbitrates five interrupt request sources for a small processor core: two external pins, two timer overflow requests and one serial port request. Every source has its own enable bit. A global enable gates them all. Each source also has a two-bit priority level, built from one bit in a "high" priority register and one bit in a "low" priority register. The block offers the CPU one vector at a time, together with that vector's level, and waits for an acknowledge pulse.

The controller keeps a four-bit in-service record, with one bit per priority level. A request is offered only when its level is strictly above the highest level in service. This gives nested preemption, and nothing can preempt level 3. A return pulse from the CPU unwinds the highest in-service level. Each external pin is active low and can be set to edge or level trigger. An edge-mode flag latches on a falling edge, and hardware clears it when that vector is acknowledged. Timer and serial requests are level inputs, and their sources clear them.

The control path is a two-state machine:
- **ST_IDLE** moves to **ST_OFFER** (transition *offer*) when an eligible candidate exists.
- **ST_OFFER** returns to ST_IDLE on acknowledge (transition *accept*), or when no eligible candidate remains (transition *withdraw*).
- While the machine stays in ST_OFFER, the presented vector follows the current best candidate (transition *refresh*).

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, irq_req is low, in_svc is 0000 and ext_pend is 00.
- R2: A source's level is {prio_hi[i], prio_lo[i]}, where 3 is the highest level and 0 the lowest. Among eligible requests the highest level is offered, whatever the source order.
- R3: Vector indices are 0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1 and 4 = serial. Among requests at the same level, the lowest index is offered.
- R4: A request is offered only if its level is strictly greater than the highest set bit of in_svc. Same-level or lower-level requests wait until a return pulse.
- R5: While in_svc bit 3 is set, no request is offered.
- R6: An acknowledge while irq_req is high sets the in_svc bit of the offered level and drops irq_req the next cycle. A reti pulse clears the highest set in_svc bit.
- R7: In edge mode (ext_edge_mode[k]=1), a high-to-low change of ext_pin_n[k] sets ext_pend[k] one cycle after the sampling edge. The flag stays set after the pin rises again, and it clears when vector 2k is acknowledged.
- R8: In level mode, ext_pend[k] equals the inverted pin. An acknowledge does not clear it.
- R9: When glob_en is low, irq_req is low from the next cycle. Edge flags still latch.
- R10: A source whose src_en bit is low is never offered.
- R11: irq_req, irq_vec and irq_lvl are registered. They rise one cycle after a request becomes eligible, and while waiting they follow the best eligible candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin_n | input | 2 | Active-low external interrupt pins |
| ext_edge_mode | input | 2 | 1 = edge trigger, 0 = level trigger, per pin |
| tmr_req | input | 2 | Timer 0/1 overflow requests (level) |
| ser_req | input | 1 | Serial port request (level) |
| src_en | input | 5 | Per-source enable, indexed by vector |
| glob_en | input | 1 | Global enable |
| prio_lo | input | 5 | Low priority bit per source |
| prio_hi | input | 5 | High priority bit per source |
| irq_ack | input | 1 | CPU acknowledge of the offered vector |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Vector offered to the CPU |
| irq_vec | output | 3 | Offered vector index |
| irq_lvl | output | 2 | Level of the offered vector |
| in_svc | output | 4 | In-service bit per level |
| ext_pend | output | 2 | Pending state of each external source |

## Verification
The arbitration is exercised with several kinds of request mix. Simultaneous same-level timer, serial and external requests separate polling order from level order. Mixed-level requests show that the level decides before the index does. A nested sequence of acknowledges and returns shows strict-greater preemption, the level-3 block and the unwinding order. Falling edges on the pins, made with the global or per-source enable off and then on, separate latching from masking, and also separate edge-flag clearing from level-trigger persistence.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int NSRC = 5;
    localparam int NEXT = 2;
    localparam int LW   = 2;
    localparam int NLVL = 1 << LW;
    localparam int VW   = $clog2(NSRC);

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } ctl_state_t;
endpackage

// File: rtl/irq_ext_trig.sv
module irq_ext_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic pend
);
    logic prev_q;
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            flag_q <= 1'b0;
        end else begin
            prev_q <= pin_n;
            if (!edge_mode)
                flag_q <= 1'b0;
            else if (prev_q && !pin_n)
                flag_q <= 1'b1;
            else if (clr)
                flag_q <= 1'b0;
        end
    end

    assign pend = edge_mode ? flag_q : ~pin_n;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_prio_pkg::*;
(
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] src_en,
    input  logic            glob_en,
    input  logic [NSRC-1:0] prio_lo,
    input  logic [NSRC-1:0] prio_hi,
    input  logic            top_valid,
    input  logic [LW-1:0]   top_lvl,
    output logic            cand_valid,
    output logic [VW-1:0]   cand_vec,
    output logic [LW-1:0]   cand_lvl
);
    logic [LW-1:0]   src_lvl [NSRC];
    logic [NSRC-1:0] act;
    logic            found;

    for (genvar s = 0; s < NSRC; s++) begin : g_lvl
        assign src_lvl[s] = {prio_hi[s], prio_lo[s]};
        assign act[s]     = pend[s] & src_en[s] & glob_en;
    end

    always_comb begin
        found    = 1'b0;
        cand_vec = '0;
        cand_lvl = '0;
        for (int lv = NLVL - 1; lv >= 0; lv--) begin
            for (int s = 0; s < NSRC; s++) begin
                if (!found && act[s] && src_lvl[s] == LW'(lv)) begin
                    found    = 1'b1;
                    cand_vec = VW'(s);
                    cand_lvl = LW'(lv);
                end
            end
        end
        cand_valid = found && (!top_valid || cand_lvl > top_lvl);
    end
endmodule

// File: rtl/irq_svc_stack.sv
module irq_svc_stack
    import irq_prio_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [LW-1:0]   set_lvl,
    input  logic            pop,
    output logic [NLVL-1:0] svc,
    output logic            top_valid,
    output logic [LW-1:0]   top_lvl
);
    logic [NLVL-1:0] svc_q;
    logic [NLVL-1:0] svc_d;

    always_comb begin
        top_valid = 1'b0;
        top_lvl   = '0;
        for (int i = 0; i < NLVL; i++) begin
            if (svc_q[i]) begin
                top_valid = 1'b1;
                top_lvl   = LW'(i);
            end
        end
    end

    always_comb begin
        svc_d = svc_q;
        if (pop && top_valid)
            svc_d[top_lvl] = 1'b0;
        if (set_en)
            svc_d[set_lvl] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            svc_q <= '0;
        else
            svc_q <= svc_d;
    end

    assign svc = svc_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEXT-1:0] ext_pin_n,
    input  logic [NEXT-1:0] ext_edge_mode,
    input  logic [1:0]      tmr_req,
    input  logic            ser_req,
    input  logic [NSRC-1:0] src_en,
    input  logic            glob_en,
    input  logic [NSRC-1:0] prio_lo,
    input  logic [NSRC-1:0] prio_hi,
    input  logic            irq_ack,
    input  logic            reti,
    output logic            irq_req,
    output logic [VW-1:0]   irq_vec,
    output logic [LW-1:0]   irq_lvl,
    output logic [NLVL-1:0] in_svc,
    output logic [NEXT-1:0] ext_pend
);
    ctl_state_t      state_q, state_d;
    logic [VW-1:0]   vec_q, vec_d;
    logic [LW-1:0]   lvl_q, lvl_d;
    logic [NSRC-1:0] pend;
    logic            accept;
    logic            cand_valid;
    logic [VW-1:0]   cand_vec;
    logic [LW-1:0]   cand_lvl;
    logic            top_valid;
    logic [LW-1:0]   top_lvl;

    assign accept = (state_q == ST_OFFER) && irq_ack;

    // External sources sit at even vector indices, timers at odd ones.
    for (genvar k = 0; k < NEXT; k++) begin : g_ext
        logic clr_k;
        assign clr_k = accept && (vec_q == VW'(2 * k));
        irq_ext_trig u_trig (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_pin_n[k]),
            .edge_mode (ext_edge_mode[k]),
            .clr       (clr_k),
            .pend      (ext_pend[k])
        );
        assign pend[2 * k]     = ext_pend[k];
        assign pend[2 * k + 1] = tmr_req[k];
    end
    assign pend[NSRC-1] = ser_req;

    irq_arbiter u_arb (
        .pend       (pend),
        .src_en     (src_en),
        .glob_en    (glob_en),
        .prio_lo    (prio_lo),
        .prio_hi    (prio_hi),
        .top_valid  (top_valid),
        .top_lvl    (top_lvl),
        .cand_valid (cand_valid),
        .cand_vec   (cand_vec),
        .cand_lvl   (cand_lvl)
    );

    irq_svc_stack u_svc (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (accept),
        .set_lvl   (lvl_q),
        .pop       (reti),
        .svc       (in_svc),
        .top_valid (top_valid),
        .top_lvl   (top_lvl)
    );

    // Next-state and capture logic.
    always_comb begin
        state_d = state_q;
        vec_d   = vec_q;
        lvl_d   = lvl_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cand_valid) begin
                    state_d = ST_OFFER;
                    vec_d   = cand_vec;
                    lvl_d   = cand_lvl;
                end
            end
            ST_OFFER: begin
                if (irq_ack) begin
                    state_d = ST_IDLE;
                end else if (cand_valid) begin
                    vec_d = cand_vec;
                    lvl_d = cand_lvl;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
            lvl_q   <= '0;
        end else begin
            state_q <= state_d;
            vec_q   <= vec_d;
            lvl_q   <= lvl_d;
        end
    end

    // Outputs.
    always_comb begin
        irq_req = (state_q == ST_OFFER);
        irq_vec = vec_q;
        irq_lvl = lvl_q;
    end
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
    import irq_prio_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            glob_en,
    input logic            irq_ack,
    input logic            reti,
    input logic            irq_req,
    input logic [VW-1:0]   irq_vec,
    input logic [LW-1:0]   irq_lvl,
    input logic [NLVL-1:0] in_svc
);
    AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> irq_vec < VW'(NSRC)); // R3

    AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((in_svc >> irq_lvl) == '0) || ((in_svc >> irq_lvl) == 1 && 1'b0)); // R4

    AST_TOP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        in_svc[NLVL-1] |-> !irq_req); // R5

    AST_ACK_SETS_LVL: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> (in_svc[$past(irq_lvl)] && !irq_req)); // R6

    AST_ONE_NEW_SVC: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_svc & ~$past(in_svc))); // R6

    AST_RETI_POPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !(irq_req && irq_ack) && in_svc != '0)
        |=> $countones(in_svc) == $countones($past(in_svc)) - 1); // R6

    AST_GLOBAL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |=> !irq_req); // R9
endmodule

bind irq_prio_ctrl irq_prio_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .glob_en (glob_en),
    .irq_ack (irq_ack),
    .reti    (reti),
    .irq_req (irq_req),
    .irq_vec (irq_vec),
    .irq_lvl (irq_lvl),
    .in_svc  (in_svc)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ext_pin_n = 2'b11;
    logic [1:0] ext_edge_mode = 2'b00;
    logic [1:0] tmr_req = 2'b00;
    logic       ser_req = 1'b0;
    logic [4:0] src_en = 5'b00000;
    logic       glob_en = 1'b0;
    logic [4:0] prio_lo = 5'b00000;
    logic [4:0] prio_hi = 5'b00000;
    logic       irq_ack = 1'b0;
    logic       reti = 1'b0;
    logic       irq_req;
    logic [2:0] irq_vec;
    logic [1:0] irq_lvl;
    logic [3:0] in_svc;
    logic [1:0] ext_pend;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_prio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n), .ext_edge_mode(ext_edge_mode),
        .tmr_req(tmr_req), .ser_req(ser_req), .src_en(src_en), .glob_en(glob_en),
        .prio_lo(prio_lo), .prio_hi(prio_hi), .irq_ack(irq_ack), .reti(reti),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl), .in_svc(in_svc),
        .ext_pend(ext_pend)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ext_pin_n = 2'b11; ext_edge_mode = 2'b00; tmr_req = 2'b00; ser_req = 1'b0;
        src_en = 5'b11111; glob_en = 1'b1; prio_lo = '0; prio_hi = '0;
        irq_ack = 1'b0; reti = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1; step(1); irq_ack = 1'b0;
    endtask

    task automatic pulse_reti();
        reti = 1'b1; step(1); reti = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 irq_req", irq_req, 0);
        check("R1 in_svc", in_svc, 0);
        check("R1 ext_pend", ext_pend, 0);
    endtask

    task automatic t_polling();
        do_reset();
        tmr_req = 2'b11; ser_req = 1'b1;
        step(1);
        check("R11 req one cycle", irq_req, 1);
        check("R3 tmr0 first", irq_vec, 1);
        tmr_req[0] = 1'b0;
        step(1);
        check("R3 tmr1 next", irq_vec, 3);
        ext_pin_n[1] = 1'b0;
        step(1);
        check("R3 ext1 over tmr1", irq_vec, 2);
        ext_pin_n[1] = 1'b1; tmr_req = 2'b00; ser_req = 1'b0;
        step(1);
        check("R11 withdraw", irq_req, 0);
    endtask

    task automatic t_levels();
        do_reset();
        prio_lo[1] = 1'b1; prio_hi[4] = 1'b1;
        tmr_req[0] = 1'b1; ser_req = 1'b1;
        step(1);
        check("R2 ser level2 wins", irq_vec, 4);
        check("R2 level", irq_lvl, 2);
        pulse_ack();
        check("R6 in_svc set", in_svc, 4'b0100);
        check("R6 req drops", irq_req, 0);
        step(2);
        check("R4 lower waits", irq_req, 0);
        prio_hi[3] = 1'b1; prio_lo[3] = 1'b1; tmr_req[1] = 1'b1;
        step(1);
        check("R4 higher preempts vec", irq_vec, 3);
        check("R4 higher preempts lvl", irq_lvl, 3);
        pulse_ack();
        check("R6 nested svc", in_svc, 4'b1100);
        prio_hi[0] = 1'b1; prio_lo[0] = 1'b1; ext_pin_n[0] = 1'b0;
        step(2);
        check("R5 level3 blocks", irq_req, 0);
        pulse_reti();
        check("R6 reti pops top", in_svc, 4'b0100);
        step(1);
        check("R3 ext0 over tmr1 at lvl3", irq_vec, 0);
        check("R4 offered after reti", irq_req, 1);
    endtask

    task automatic t_edge();
        do_reset();
        ext_edge_mode[0] = 1'b1;
        step(2);
        ext_pin_n[0] = 1'b0;
        step(1);
        check("R7 flag after edge", ext_pend[0], 1);
        check("R11 req not yet", irq_req, 0);
        ext_pin_n[0] = 1'b1;
        step(1);
        check("R7 request", irq_req, 1);
        check("R7 vec", irq_vec, 0);
        check("R7 flag held", ext_pend[0], 1);
        pulse_ack();
        check("R7 flag cleared by ack", ext_pend[0], 0);
        check("R6 in_svc lvl0", in_svc, 4'b0001);
    endtask

    task automatic t_level_trig();
        do_reset();
        ext_pin_n[1] = 1'b0;
        step(1);
        check("R8 level request", irq_vec, 2);
        pulse_ack();
        check("R8 pend stays", ext_pend[1], 1);
        step(2);
        check("R4 same level waits", irq_req, 0);
        pulse_reti();
        check("R6 reti empties", in_svc, 0);
        step(1);
        check("R8 re-request", irq_req, 1);
    endtask

    task automatic t_global();
        do_reset();
        glob_en = 1'b0; ext_edge_mode[0] = 1'b1;
        step(2);
        ext_pin_n[0] = 1'b0;
        step(2);
        check("R9 flag latches", ext_pend[0], 1);
        check("R9 masked", irq_req, 0);
        glob_en = 1'b1;
        step(1);
        check("R9 released", irq_req, 1);
    endtask

    task automatic t_src_en();
        do_reset();
        src_en = 5'b11101; tmr_req[0] = 1'b1;
        step(2);
        check("R10 masked source", irq_req, 0);
        src_en = 5'b11111;
        step(1);
        check("R10 unmasked vec", irq_vec, 1);
    endtask

    initial begin
        t_reset();
        t_polling();
        t_levels();
        t_edge();
        t_level_trig();
        t_global();
        t_src_en();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule